// File: doc/BRIEF.md
# Two-Digit Seconds Counter with Seven-Segment Outputs

This block counts rising clock edges from 00 up to 59, then starts again at 00. It shows the two decimal digits on two active-low seven-segment buses. The clock may come from any pulse source, for example a debounced push button. An active-low reset brings the display back to 00.

The two digits are built from two copies of one decade-style counter module. A parameter sets the value at which a copy wraps: ten for the units digit and six for the tens digit. The units copy advances on every edge. During the one cycle in which the units copy is about to wrap, it raises a carry, and that carry enables the tens copy. The carry out of the tens copy leaves the block as a one-cycle pulse that marks each full minute. A separate combinational decoder drives each digit. The decoder shows the letter E for any 4-bit code above nine.

Top module: `minsec_counter`

## Requirements
- R1: The counter module takes its wrap value as a parameter. With the value ten the units digit shows only 0 to 9, and with the value six the tens digit shows only 0 to 5.
- R2: While rst_n is low at a rising clock edge, both digits become 0 at that edge. minute_pulse stays low for as long as rst_n is low.
- R3: The units digit increases by one on every rising edge out of reset, and it goes from 9 to 0.
- R4: The tens digit changes only on an edge at which the units digit goes from 9 to 0. On that edge it increases by one, or goes from 5 to 0, so 59 is followed by 00.
- R5: minute_pulse is high exactly during the single cycle in which the display reads 59, and it is low in every other cycle.
- R6: The decoder bus carries segments g,f,e,d,c,b,a on bits 6 down to 0, and a 0 lights a segment. Codes 0 to 9 give 40, 79, 24, 30, 19, 12, 02, 78, 00 and 10 (hex).
- R7: The decoder gives the letter E, 06 hex (segments a, d, e, f, g lit), for every code from 10 to 15.
- R8: If reset is applied in the middle of a count, the display reads 00. The first edge after rst_n goes high shows 01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| seg_units | output | 7 | Units digit segments, active low, bit 6 = g, bit 0 = a |
| seg_tens | output | 7 | Tens digit segments, active low, bit 6 = g, bit 0 = a |
| minute_pulse | output | 1 | High during the cycle in which the display reads 59 |

## Verification
The two counters can only ever produce codes 0 to 9, so the letter-E patterns of the decoder cannot be reached from the top-level ports. The bench therefore drives a second, stand-alone decoder through all sixteen codes. The 59-to-00 rollover and the minute pulse only appear after sixty edges. The bench counts through more than two full minutes, then resets in the middle of a count and runs another full minute, so that the wrap, the pulse and the restart from reset are each seen several times.

// File: rtl/minsec_pkg.sv
// Package minsec_pkg
// Shared widths, types and segment constants for the seconds counter.
// Assumes active-low segments ordered g (bit 6) down to a (bit 0).
package minsec_pkg;
    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;
    localparam int N_DIGITS = 2;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [SEG_W-1:0]   seg_t;

    localparam seg_t SEG_BLANK = 7'h7F;
    localparam seg_t SEG_ERR_E = 7'h06;
endpackage

// File: rtl/bcd_digit_counter.sv
// Module bcd_digit_counter
// One decimal-style digit. It advances by one on each enabled rising edge and
// wraps to zero after TERMINAL-1. The carry is combinational: it is high during
// the enabled cycle whose edge performs the wrap.
// Assumes TERMINAL is between 2 and 2**CNT_W and that the reset is synchronous and active low.
module bcd_digit_counter #(
    parameter int                CNT_W    = 4,
    parameter logic [CNT_W-1:0]  TERMINAL = 4'd10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] count,
    output logic             carry
);
    localparam logic [CNT_W-1:0] LAST = TERMINAL - 1'b1;

    logic at_last;

    // Flag the last value before the wrap
    always_comb begin
        at_last = (count == LAST);
    end

    // Count register: clear on reset, wrap after the last value, otherwise step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (en) begin
            if (at_last) begin
                count <= '0;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    // Carry for the next digit, held low during reset
    always_comb begin
        carry = rst_n & en & at_last;
    end
endmodule

// File: rtl/seg7_decoder.sv
// Module seg7_decoder
// Turns a 4-bit code into active-low segments (g..a on bits 6..0).
// Codes 0-9 give the digits and 10-15 give the letter E. Any other value,
// such as an unknown in simulation, blanks the digit.
module seg7_decoder
    import minsec_pkg::*;
(
    input  digit_t code,
    output seg_t   seg
);
    // Table lookup from code to segment pattern
    always_comb begin
        case (code)
            4'd0:    seg = 7'h40;
            4'd1:    seg = 7'h79;
            4'd2:    seg = 7'h24;
            4'd3:    seg = 7'h30;
            4'd4:    seg = 7'h19;
            4'd5:    seg = 7'h12;
            4'd6:    seg = 7'h02;
            4'd7:    seg = 7'h78;
            4'd8:    seg = 7'h00;
            4'd9:    seg = 7'h10;
            4'd10, 4'd11, 4'd12,
            4'd13, 4'd14, 4'd15:
                     seg = SEG_ERR_E;
            default: seg = SEG_BLANK;
        endcase
    end
endmodule

// File: rtl/minsec_counter.sv
// Module minsec_counter
// Counts from 00 to 59 on rising clock edges and drives two active-low
// seven-segment digits. The carry of each digit enables the next one, and the
// carry of the last digit leaves the block as minute_pulse.
// Assumes clk is already free of bounce and that rst_n is synchronous, active low.
module minsec_counter
    import minsec_pkg::*;
#(
    parameter logic [DIGIT_W-1:0] UNITS_TERM = 4'd10,
    parameter logic [DIGIT_W-1:0] TENS_TERM  = 4'd6
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SEG_W-1:0] seg_units,
    output logic [SEG_W-1:0] seg_tens,
    output logic             minute_pulse
);
    logic [N_DIGITS:0]   en_chain;
    digit_t              digit_q [N_DIGITS];
    seg_t                digit_seg [N_DIGITS];

    // The lowest digit counts on every edge
    assign en_chain[0] = 1'b1;

    // One counter and one decoder per digit; each carry enables the next digit
    for (genvar i = 0; i < N_DIGITS; i++) begin : g_digit
        bcd_digit_counter #(
            .CNT_W    (DIGIT_W),
            .TERMINAL ((i == 0) ? UNITS_TERM : TENS_TERM)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_chain[i]),
            .count (digit_q[i]),
            .carry (en_chain[i+1])
        );

        seg7_decoder u_dec (
            .code (digit_q[i]),
            .seg  (digit_seg[i])
        );
    end

    // Route the digit segments and the minute carry to the ports
    assign seg_units    = digit_seg[0];
    assign seg_tens     = digit_seg[1];
    assign minute_pulse = en_chain[N_DIGITS];
endmodule

// File: rtl/minsec_counter_chk.sv
// Module minsec_counter_chk
// Timing properties on the ports of minsec_counter, attached with bind.
module minsec_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] seg_units,
    input logic [6:0] seg_tens,
    input logic       minute_pulse
);
    localparam logic [6:0] P0 = 7'h40;
    localparam logic [6:0] P5 = 7'h12;
    localparam logic [6:0] P9 = 7'h10;
    localparam logic [6:0] PE = 7'h06;
    localparam logic [6:0] PB = 7'h7F;

    // R2: reset held at an edge leaves 00 on the display once released
    a_r2_cleared_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (seg_units == P0 && seg_tens == P0));

    // R2: minute pulse low during reset
    a_r2_pulse_low_in_reset: assert property (@(posedge clk)
        !rst_n |-> !minute_pulse);

    // R3: units 9 is followed by units 0
    a_r3_units_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_units == P9) |=> (seg_units == P0));

    // R4: tens digit holds unless the units digit wraps
    a_r4_tens_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_units != P9) |=> $stable(seg_tens));

    // R4: 59 is followed by 00
    a_r4_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_tens == P5 && seg_units == P9) |=> (seg_tens == P0 && seg_units == P0));

    // R5: pulse only while showing 59
    a_r5_pulse_at_59: assert property (@(posedge clk) disable iff (!rst_n)
        minute_pulse |-> (seg_tens == P5 && seg_units == P9));

    // R5: pulse lasts one cycle
    a_r5_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        minute_pulse |=> !minute_pulse);

    // R1: counters never produce a non-decimal code
    a_r1_no_error_code: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_units != PE && seg_tens != PE && seg_units != PB && seg_tens != PB));
endmodule

bind minsec_counter minsec_counter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .seg_units    (seg_units),
    .seg_tens     (seg_tens),
    .minute_pulse (minute_pulse)
);

// File: tb/minsec_counter_tb.sv
module minsec_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] seg_units;
    logic [6:0] seg_tens;
    logic       minute_pulse;
    logic [3:0] dec_code = 4'd0;
    logic [6:0] dec_seg;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int model    = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    minsec_counter u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .seg_units    (seg_units),
        .seg_tens     (seg_tens),
        .minute_pulse (minute_pulse)
    );

    seg7_decoder u_dec (
        .code (dec_code),
        .seg  (dec_seg)
    );

    function automatic logic [6:0] pat(input int d);
        case (d)
            0: return 7'h40;  1: return 7'h79;  2: return 7'h24;
            3: return 7'h30;  4: return 7'h19;  5: return 7'h12;
            6: return 7'h02;  7: return 7'h78;  8: return 7'h00;
            9: return 7'h10;
            default: return 7'h06;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Behavioural reference: seconds value advanced on each edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) model = 0;
        else        model = (model + 1) % 60;
        if (cycles > 5000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 5000 cycles", cycles);
            finish_run();
        end
    end

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        if (cycles > 0 && !done) begin
            check("R3 units digit", seg_units, pat(model % 10));
            check("R4 tens digit", seg_tens, pat(model / 10));
            check("R5 minute pulse", minute_pulse, (rst_n && model == 59) ? 1 : 0);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R2 reset units", seg_units, 7'h40);
        check("R2 reset tens", seg_tens, 7'h40);
        check("R2 pulse in reset", minute_pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 first edge after reset", seg_units, 7'h79);
        repeat (128) @(negedge clk);
        // mid-count reset (R8)
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset clears units", seg_units, 7'h40);
        check("R8 reset clears tens", seg_tens, 7'h40);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 resume at 01", seg_units, 7'h79);
        check("R8 resume tens 0", seg_tens, 7'h40);
        repeat (70) @(negedge clk);
        // stand-alone decoder over all codes (R6, R7)
        for (int c = 0; c < 16; c++) begin
            dec_code = c[3:0];
            #1;
            if (c < 10) check("R6 digit pattern", dec_seg, pat(c));
            else        check("R7 letter E", dec_seg, 7'h06);
        end
        finish_run();
    end
endmodule